// File: doc/BRIEF.md
# EDO DRAM Device Behavioural Core

This block is a synthesizable, clock-sampled stand-in for an asynchronous-strobe dynamic RAM with extended-data-out page mode. It serves as a test target for a memory controller. Each rising edge of `clk_i` samples the active-low row strobe, column strobe, write enable and output enable, together with a 10-bit multiplexed address. The operation type comes from the order in which the strobes fall, not from a command code. The operations are standby, read, early write, read-modify-write, page-mode access, row-only refresh and column-before-row refresh.

The data bus is split into `dq_i`, `dq_o` and an output-enable `dq_oe_o` that drives an external tristate pad. The storage array is `2**(ROW_W+COL_W)` bytes, so it fits in on-chip memory. The array is indexed by the low `ROW_W` bits of the latched row and the low `COL_W` bits of the latched column. Upper address bits are accepted and alias. A debug port reports the decoded cycle type and the internal refresh row counter.

All outputs are registered. They reflect the input levels sampled at the preceding rising clock edge. Two rules apply to the controller: the row strobe must fall at least one sample before the first column strobe falls, and that column strobe must fall in a later sample than the row strobe.

Top module: `edo_dram_core`

## Requirements
- R1: After reset, `dq_oe_o` is 0, `cyc_o` is 0 (idle) and `rfsh_row_o` is 0.
- R2: The row is latched from `addr_i` when the row strobe falls and the column from `addr_i` when the column strobe falls. The array cell is `{row[ROW_W-1:0], col[COL_W-1:0]}`, so upper address bits alias. With defaults, row 0x3F3 and column 0x2A5 select the same cell as row 3, column 5.
- R3: If write enable is already low when the column strobe falls (early write), `dq_i` is stored and `cyc_o` is 3. `dq_oe_o` stays 0 until the next column strobe falls.
- R4: If write enable is high when the column strobe falls, the cell is read and `cyc_o` is 2. Data is driven only while output enable is low, so it is driven from the later of the column-strobe fall and the output-enable fall. Raising output enable while the column strobe is low turns the bus off.
- R5: With the row strobe held low, read data stays driven after the column strobe rises. It is replaced only at the next column-strobe fall, which latches a new column in the same row.
- R6: If write enable falls while the column strobe is low in a read, `dq_i` is written to the latched cell and `cyc_o` becomes 4. The bus keeps showing the data read before the write.
- R7: A row-strobe fall with the column strobe high reports `cyc_o` 1. It drives no data and leaves the array unchanged, whatever write enable and `dq_i` are.
- R8: If the column strobe was already low in the sample before the row strobe falls, `cyc_o` is 5. `addr_i`, write enable and `dq_i` are ignored, the array is unchanged, and `dq_oe_o` stays 0 even with output enable low.
- R9: `rfsh_row_o` increments by one when the row strobe rises at the end of a column-before-row cycle, and wraps from 1023 to 0.
- R10: When both strobes are sampled high, `dq_oe_o` is 0 one edge later and `cyc_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (10) | Multiplexed row/column address |
| dq_i | input | DATA_W (8) | Write data from the bus |
| dq_o | output | DATA_W (8) | Read data latch, valid while dq_oe_o is 1 |
| dq_oe_o | output | 1 | Bus drive enable for the tristate pad |
| cyc_o | output | 3 | Cycle type: 0 idle, 1 row-only, 2 read, 3 early write, 4 read-modify-write, 5 refresh |
| rfsh_row_o | output | ADDR_W (10) | Internal refresh row counter |

## Verification
The bench writes every cell of the default array by early writes and reads it back in page mode. After each column-strobe rise it checks that the data is still driven. A core that released data on that rise, as a fast-page part does, fails here, and so does one that mixed up row and column. It runs a read-modify-write and checks that the bus still shows the old byte while the new one lands in the array. It also drives garbage data with write enable low during row-only and refresh cycles, so a core that decoded those as writes would corrupt cells that are read later. Finally, 1024 refresh cycles check the counter step and its wrap to 0.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_ROWONLY = 3'd1,
    CYC_READ    = 3'd2,
    CYC_EWRITE  = 3'd3,
    CYC_RMW     = 3'd4,
    CYC_CBR     = 3'd5
  } cyc_e;
endpackage

// File: rtl/edo_cycle_ctrl.sv
module edo_cycle_ctrl
  import edo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  localparam int IDX_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_en_o,
  output logic              rd_load_o,
  output logic              drive_o,
  output logic              cbr_end_o,
  output cyc_e              cyc_o
);
  logic ras_q, cas_q, we_q, oe_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  cyc_e cyc_q, cyc_d;
  logic dvalid_q, dvalid_d;

  logic ras_fall, ras_rise, cas_fall, we_fall, in_access, col_strobe, rmw_strobe, cbr_start;

  assign ras_fall   = ras_q & ~ras_ni;
  assign ras_rise   = ~ras_q & ras_ni;
  assign cas_fall   = cas_q & ~cas_ni;
  assign we_fall    = we_q & ~we_ni;
  assign cbr_start  = ras_fall & ~cas_q & ~cas_ni;
  assign in_access  = ~ras_q & ~ras_ni & (cyc_q != CYC_CBR);
  assign col_strobe = in_access & cas_fall;
  assign rmw_strobe = in_access & ~cas_q & ~cas_ni & we_fall & (cyc_q == CYC_READ);

  assign idx_o     = col_strobe ? {row_q, addr_i[COL_W-1:0]} : {row_q, col_q};
  assign wr_en_o   = (col_strobe & ~we_ni) | rmw_strobe;
  assign rd_load_o = col_strobe & we_ni;
  assign cbr_end_o = ras_rise & (cyc_q == CYC_CBR);
  assign drive_o   = dvalid_q & ~oe_q & ~(ras_q & cas_q);
  assign cyc_o     = cyc_q;

  always_comb begin
    cyc_d    = cyc_q;
    dvalid_d = dvalid_q;
    if (ras_fall) begin
      cyc_d    = cbr_start ? CYC_CBR : CYC_ROWONLY;
      dvalid_d = 1'b0;
    end else if (ras_rise) begin
      cyc_d = CYC_IDLE;
    end else if (col_strobe) begin
      cyc_d    = we_ni ? CYC_READ : CYC_EWRITE;
      dvalid_d = we_ni;
    end else if (rmw_strobe) begin
      cyc_d = CYC_RMW;
    end
    if (ras_ni & cas_ni) dvalid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      we_q     <= 1'b1;
      oe_q     <= 1'b1;
      row_q    <= '0;
      col_q    <= '0;
      cyc_q    <= CYC_IDLE;
      dvalid_q <= 1'b0;
    end else begin
      ras_q    <= ras_ni;
      cas_q    <= cas_ni;
      we_q     <= we_ni;
      oe_q     <= oe_ni;
      cyc_q    <= cyc_d;
      dvalid_q <= dvalid_d;
      if (ras_fall && !cbr_start) row_q <= addr_i[ROW_W-1:0];
      if (col_strobe) col_q <= addr_i[COL_W-1:0];
    end
  end

  AST_WR_NEEDS_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (!ras_ni && !cas_ni)); // R3
  AST_ROWONLY_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_ROWONLY && cas_ni) |-> !wr_en_o); // R7
  AST_CBR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_CBR) |-> !wr_en_o); // R8
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int REF_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [REF_W-1:0] row_o
);
  logic [REF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + REF_W'(1);
  end

  assign row_o = cnt_q;

  AST_REF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_q == $past(cnt_q) + REF_W'(1))); // R9
  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[idx_i];
endmodule

// File: rtl/edo_dram_core.sv
module edo_dram_core
  import edo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  localparam int IDX_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [2:0]        cyc_o,
  output logic [ADDR_W-1:0] rfsh_row_o
);
  logic [IDX_W-1:0]  idx;
  logic              wr_en, rd_load, drive, cbr_end;
  logic [DATA_W-1:0] rd_data, dout_q;
  cyc_e              cyc;

  edo_cycle_ctrl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk_i, .rst_ni, .ras_ni, .cas_ni, .we_ni, .oe_ni, .addr_i,
    .idx_o(idx), .wr_en_o(wr_en), .rd_load_o(rd_load), .drive_o(drive),
    .cbr_end_o(cbr_end), .cyc_o(cyc)
  );

  edo_cell_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .idx_i(idx), .wr_en_i(wr_en), .wr_data_i(dq_i), .rd_data_o(rd_data)
  );

  edo_refresh_ctr #(.REF_W(ADDR_W)) u_rfsh (
    .clk_i, .rst_ni, .inc_i(cbr_end), .row_o(rfsh_row_o)
  );

  // EDO latch: replaced only by the next read column strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dout_q <= '0;
    else if (rd_load) dout_q <= rd_data;
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = drive;
  assign cyc_o   = cyc;

  AST_CBR_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_CBR) |-> !dq_oe_o); // R8
  AST_EWRITE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_EWRITE) |-> !dq_oe_o); // R3
  AST_IDLE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && cas_ni) |=> !dq_oe_o); // R10
  AST_RMW_KEEPS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_RMW && !rd_load) |=> $stable(dq_o)); // R6
endmodule

// File: tb/sim_edo_dram_core.sv
module sim_edo_dram_core;
  logic clk = 0, rst_n = 0;
  logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
  logic [9:0] addr = '0;
  logic [7:0] dq_in = '0, dq_out;
  logic dq_oe;
  logic [2:0] cyc;
  logic [9:0] rrow;
  int checks = 0, errors = 0;
  logic [7:0] exp_mem [256];
  int ref_exp = 0;

  always #5 clk = ~clk;

  edo_dram_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .cyc_o(cyc), .rfsh_row_o(rrow)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int r, input int c);
    return 8'((r * 37 + c * 11) ^ 8'h5A);
  endfunction

  task automatic open_row(input logic [9:0] r);
    addr = r; ras_n = 0; tick();
    chk(cyc == 3'd1, "R7 row open", cyc, 1);
  endtask

  task automatic close_row();
    ras_n = 1; cas_n = 1; oe_n = 1; we_n = 1; tick();
    chk(!dq_oe && cyc == 3'd0, "R10 standby", {dq_oe, cyc}, 0);
  endtask

  task automatic early_wr(input logic [9:0] c, input logic [7:0] d);
    addr = c; we_n = 0; dq_in = d; oe_n = 0; cas_n = 0; tick();
    chk(cyc == 3'd3 && !dq_oe, "R3 early write", {dq_oe, cyc}, 3);
    cas_n = 1; we_n = 1; tick();
    chk(!dq_oe, "R3 hi-z after cas rise", dq_oe, 0);
    oe_n = 1;
  endtask

  task automatic page_rd(input logic [9:0] c, input logic [7:0] e, input string req);
    addr = c; we_n = 1; oe_n = 0; cas_n = 0; tick();
    chk(dq_oe && dq_out == e && cyc == 3'd2, req, {dq_oe, dq_out}, {1'b1, e});
    cas_n = 1; addr = 10'h3FF; tick();
    chk(dq_oe && dq_out == e, "R5 edo hold", {dq_oe, dq_out}, {1'b1, e});
  endtask

  task automatic cbr_cycle(input bit check_it);
    cas_n = 0; tick();
    addr = 10'h155; we_n = 0; dq_in = 8'hEE; oe_n = 0; ras_n = 0; tick();
    if (check_it) chk(cyc == 3'd5 && !dq_oe, "R8 cbr decode", {dq_oe, cyc}, 5);
    tick();
    if (check_it) chk(!dq_oe, "R8 cbr hi-z", dq_oe, 0);
    ras_n = 1; tick();
    ref_exp = (ref_exp + 1) % 1024;
    if (check_it) chk(rrow == 10'(ref_exp), "R9 counter step", rrow, ref_exp);
    cas_n = 1; we_n = 1; oe_n = 1; tick();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(!dq_oe && cyc == 3'd0 && rrow == 10'd0, "R1 reset", {dq_oe, cyc, rrow}, 0);
    rst_n = 1; tick();

    // full sweep: page-mode early writes, then page-mode reads
    for (int r = 0; r < 16; r++) begin
      open_row(10'(r));
      for (int c = 0; c < 16; c++) begin
        early_wr(10'(c), pat(r, c));
        exp_mem[r * 16 + c] = pat(r, c);
      end
      close_row();
    end
    for (int r = 0; r < 16; r++) begin
      open_row(10'(r));
      for (int c = 0; c < 16; c++) page_rd(10'(c), exp_mem[r * 16 + c], "R2 page read");
      close_row();
    end

    // R2 aliasing of upper address bits
    open_row(10'h3F3);
    page_rd(10'h2A5, exp_mem[3 * 16 + 5], "R2 alias");
    close_row();

    // R4 output enable falling after column strobe, then early release
    open_row(10'd2);
    addr = 10'd7; oe_n = 1; cas_n = 0; tick();
    chk(!dq_oe, "R4 oe high hi-z", dq_oe, 0);
    oe_n = 0; tick();
    chk(dq_oe && dq_out == exp_mem[2 * 16 + 7], "R4 late oe", dq_out, exp_mem[2 * 16 + 7]);
    oe_n = 1; tick();
    chk(!dq_oe, "R4 oe release", dq_oe, 0);
    close_row();

    // R6 read-modify-write
    open_row(10'd4);
    addr = 10'd9; oe_n = 0; cas_n = 0; tick();
    chk(dq_oe && dq_out == exp_mem[4 * 16 + 9], "R6 read phase", dq_out, exp_mem[4 * 16 + 9]);
    oe_n = 1; we_n = 0; dq_in = 8'hC3; tick();
    chk(cyc == 3'd4, "R6 rmw decode", cyc, 4);
    oe_n = 0; tick();
    chk(dq_oe && dq_out == exp_mem[4 * 16 + 9], "R6 old data kept", dq_out, exp_mem[4 * 16 + 9]);
    exp_mem[4 * 16 + 9] = 8'hC3;
    close_row();
    open_row(10'd4);
    page_rd(10'd9, 8'hC3, "R6 new data stored");
    close_row();

    // R7 row-only refresh with write enable low
    addr = 10'd6; we_n = 0; dq_in = 8'hFF; oe_n = 0; ras_n = 0; tick();
    chk(cyc == 3'd1 && !dq_oe, "R7 row-only", {dq_oe, cyc}, 1);
    tick(); tick();
    chk(!dq_oe, "R7 no drive", dq_oe, 0);
    close_row();
    open_row(10'd6);
    for (int c = 0; c < 16; c++) page_rd(10'(c), exp_mem[6 * 16 + c], "R7 array intact");
    close_row();

    // R8/R9 refresh cycles and wrap
    cbr_cycle(1'b1);
    cbr_cycle(1'b1);
    open_row(10'h155 & 10'hF);
    for (int c = 0; c < 16; c++) page_rd(10'(c), exp_mem[5 * 16 + c], "R8 array intact");
    close_row();
    while (ref_exp != 1023) cbr_cycle(1'b0);
    chk(rrow == 10'd1023, "R9 before wrap", rrow, 1023);
    cbr_cycle(1'b1);
    chk(rrow == 10'd0, "R9 wrap", rrow, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule